// File: doc/BRIEF.md
# Opcode Byte Decoder with Trailing Word Assembly

This block sits at the front of a small 16-bit processor that has four general registers. It watches a stream of instruction bytes, one byte per accepted cycle. Whenever a byte arrives in the opcode phase, the block decodes it combinationally in the same cycle. The decode gives the operation, the register select, the operand mode select, a flag saying whether a 16-bit word follows, the total instruction length, an illegal flag and an expansion-prefix flag.

When a word follows, the block takes the next two accepted bytes as operand bytes and does not decode them. The first of these bytes is the low half. The assembled value is presented for one cycle after the high byte has been taken. A byte that follows the expansion prefix is handed on as a new-scheme opcode. It is not decoded by this scheme.

The opcode byte has three fields. Bits 7:5 give the class. Bits 4:3 give the register, with 0 to 3 meaning AX to DX. Bits 2:0 give the operand mode: 0 to 3 select a register, 4 is indirect through BX, 5 is BX plus a word displacement, 6 is a direct word address and 7 is a word immediate. Class 0 is an escape class, and bits 4:3 then pick a sub-group inside it.

Top module: `opbyte_decoder`

## Requirements
- R1: On every decoded byte, `reg_sel` equals bits 4:3 and `mode_sel` equals bits 2:0 of that byte.
- R2: Classes 1 to 6 (bits 7:5) map to op codes 0 OR, 1 AND, 2 CMP, 3 SUB, 4 ADD and 5 load-register. Every mode value is legal in these classes.
- R3: For classes 1 to 7 and for NOT, modes 5, 6 and 7 set `has_word` and give `inst_len` 3. Any other legal, non-prefix byte gives `has_word` 0 and `inst_len` 1.
- R4: In class 7 (store register, op 6), only modes 4, 5 and 6 are legal. Modes 0 to 3 and mode 7 give op 14 with `illegal` set, `has_word` 0 and `inst_len` 1. Byte 0xFF is the exception and falls under R8.
- R5: In class 0, sub-group 0 (bytes 0x03 to 0x07) gives op 9 to 13 in that order: break, interrupt return, halt, get, put. Bytes 0x00 to 0x02 and sub-group 3 (0x18 to 0x1F) are illegal.
- R6: Bytes 0x08 to 0x0E give op 7 (jump), with the condition in `mode_sel`, `has_word` 1 and `inst_len` 3. Byte 0x0F is illegal.
- R7: Bytes 0x10 to 0x16 give op 8 (NOT), and the word rule of R3 applies. Byte 0x17 is illegal.
- R8: Byte 0xFF gives op 15 with `prefix` 1, `illegal` 0, `has_word` 0 and `inst_len` 0. The next accepted byte raises `ext_valid` and is not decoded.
- R9: After a byte with `has_word`, the next two accepted bytes form `word_value` = {second, first}. `word_valid` pulses for exactly one cycle, in the cycle after the second byte is accepted. Cycles with `in_valid` low do not advance the collection.
- R10: `dec_valid` is high only when an accepted byte is in the opcode phase, and it is low while operand bytes or the prefixed byte are taken. After an illegal byte, the next byte is an opcode.
- R11: After reset, the block is in the opcode phase and `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_byte | input | 8 | Instruction stream byte |
| dec_valid | output | 1 | The current byte is decoded as an opcode |
| op_code | output | 4 | Decoded operation (R2 to R8 codes) |
| reg_sel | output | 2 | Register field |
| mode_sel | output | 3 | Operand mode or jump condition field |
| has_word | output | 1 | A 16-bit word follows |
| inst_len | output | 2 | Total length in bytes, 0 for the prefix |
| illegal | output | 1 | Illegal opcode, qualified by dec_valid |
| prefix | output | 1 | Expansion prefix, qualified by dec_valid |
| ext_valid | output | 1 | The current byte is a new-scheme opcode after the prefix |
| word_valid | output | 1 | One-cycle pulse: the assembled word is ready |
| word_value | output | 16 | Assembled little-endian word |

## Verification
Suppose the collector's phase is wrong, for example it misses a return to the opcode phase or counts one byte too many. The next byte is then decoded when it should be swallowed, or swallowed when it should be decoded, and `dec_valid` differs in that same cycle. A wrong byte count or a wrong byte order shows in `word_valid` or `word_value` one cycle after the last operand byte. A wrong decode table shows combinationally in the very cycle the opcode is accepted. All 256 opcodes are swept, followed by a long random stream with idle gaps.

// File: rtl/idec_pkg.sv
`timescale 1ns/1ps
package idec_pkg;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 2;
  localparam int MODE_W = 3;
  localparam int CLS_W  = 3;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    OP_OR   = 4'd0,  OP_AND  = 4'd1,  OP_CMP  = 4'd2,  OP_SUB  = 4'd3,
    OP_ADD  = 4'd4,  OP_LDR  = 4'd5,  OP_STR  = 4'd6,  OP_JUMP = 4'd7,
    OP_NOT  = 4'd8,  OP_BRK  = 4'd9,  OP_IRET = 4'd10, OP_HALT = 4'd11,
    OP_GET  = 4'd12, OP_PUT  = 4'd13, OP_ILL  = 4'd14, OP_PFX  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_WORD = 2'd1,
    PH_EXT  = 2'd2
  } phase_e;

  typedef struct packed {
    op_e        op;
    logic       has_word;
    logic [1:0] len;
    logic       illegal;
    logic       prefix;
  } dec_t;

  // Modes 5,6,7 carry a trailing word.
  function automatic logic mode_has_word(input logic [MODE_W-1:0] m);
    return m[2] & (m[1] | m[0]);
  endfunction

  // Store class accepts only the memory modes 4,5,6.
  function automatic logic store_mode_ok(input logic [MODE_W-1:0] m);
    return m[2] & ~(m[1] & m[0]);
  endfunction

  function automatic logic [1:0] length_of(input logic pfx, input logic word);
    if (pfx)       return 2'd0;
    else if (word) return 2'd3;
    else           return 2'd1;
  endfunction
endpackage

// File: rtl/idec_escape_decode.sv
`timescale 1ns/1ps
module idec_escape_decode
  import idec_pkg::*;
(
  input  logic [REG_W-1:0]  grp,
  input  logic [MODE_W-1:0] sel,
  output op_e               op,
  output logic              has_word,
  output logic              illegal
);
  always_comb begin
    op       = OP_ILL;
    has_word = 1'b0;
    illegal  = 1'b1;
    unique case (grp)
      2'd0: begin
        if (sel >= 3'd3) begin
          op      = op_e'(4'(OP_BRK) + 4'(sel - 3'd3));
          illegal = 1'b0;
        end
      end
      2'd1: begin
        if (sel != 3'd7) begin
          op       = OP_JUMP;
          has_word = 1'b1;
          illegal  = 1'b0;
        end
      end
      2'd2: begin
        if (sel != 3'd7) begin
          op       = OP_NOT;
          has_word = mode_has_word(sel);
          illegal  = 1'b0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_field_decode.sv
`timescale 1ns/1ps
module idec_field_decode
  import idec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PREFIX_CODE = 8'hFF
) (
  input  logic [OPC_W-1:0]  opc,
  output dec_t              dec,
  output logic [REG_W-1:0]  rsel,
  output logic [MODE_W-1:0] msel
);
  localparam int CLS_LSB = REG_W + MODE_W;

  logic [CLS_W-1:0] cls;
  op_e              esc_op;
  logic             esc_word;
  logic             esc_ill;
  logic             is_pfx;

  assign cls    = opc[CLS_LSB +: CLS_W];
  assign rsel   = opc[MODE_W +: REG_W];
  assign msel   = opc[MODE_W-1:0];
  assign is_pfx = (opc == PREFIX_CODE);

  idec_escape_decode u_esc (
    .grp      (rsel),
    .sel      (msel),
    .op       (esc_op),
    .has_word (esc_word),
    .illegal  (esc_ill)
  );

  always_comb begin
    dec.prefix   = 1'b0;
    dec.illegal  = 1'b0;
    dec.has_word = 1'b0;
    dec.op       = OP_ILL;
    if (is_pfx) begin
      dec.op     = OP_PFX;
      dec.prefix = 1'b1;
    end else if (cls == '0) begin
      dec.op       = esc_op;
      dec.has_word = esc_word;
      dec.illegal  = esc_ill;
    end else if (cls == '1) begin
      if (store_mode_ok(msel)) begin
        dec.op       = OP_STR;
        dec.has_word = mode_has_word(msel);
      end else begin
        dec.illegal = 1'b1;
      end
    end else begin
      dec.op       = op_e'(4'(cls) - 4'd1);
      dec.has_word = mode_has_word(msel);
    end
    dec.len = length_of(dec.prefix, dec.has_word);
  end
endmodule

// File: rtl/idec_word_collect.sv
`timescale 1ns/1ps
module idec_word_collect
  import idec_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          start_word,
  input  logic          start_ext,
  output phase_e        phase,
  output logic          wvalid,
  output logic [W-1:0]  wvalue
);
  localparam int NB    = W / 8;
  localparam int CNT_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NB - 1);

  logic [CNT_W-1:0] cnt;
  logic             last_byte;

  assign last_byte = in_valid && (phase == PH_WORD) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_OPC;
      cnt    <= '0;
      wvalue <= '0;
      wvalid <= 1'b0;
    end else begin
      wvalid <= 1'b0;
      if (in_valid) begin
        unique case (phase)
          PH_OPC: begin
            if (start_ext) phase <= PH_EXT;
            else if (start_word) begin
              phase <= PH_WORD;
              cnt   <= '0;
            end
          end
          PH_WORD: begin
            wvalue <= {in_byte, wvalue[W-1:8]};
            if (cnt == LAST) begin
              phase  <= PH_OPC;
              wvalid <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= PH_OPC;
        endcase
      end
    end
  end

  p_pulse_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> $past(last_byte));
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |=> !wvalid);
  p_enter_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase == PH_OPC && start_word && !start_ext) |=> phase == PH_WORD);
  p_ext_one_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase == PH_EXT) |=> phase == PH_OPC);
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));
endmodule

// File: rtl/opbyte_decoder.sv
`timescale 1ns/1ps
module opbyte_decoder
  import idec_pkg::*;
#(
  parameter logic [7:0] PREFIX_CODE = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        dec_valid,
  output logic [3:0]  op_code,
  output logic [1:0]  reg_sel,
  output logic [2:0]  mode_sel,
  output logic        has_word,
  output logic [1:0]  inst_len,
  output logic        illegal,
  output logic        prefix,
  output logic        ext_valid,
  output logic        word_valid,
  output logic [15:0] word_value
);
  dec_t   dec;
  phase_e phase;
  logic   opc_phase;
  logic   start_word;
  logic   start_ext;

  idec_field_decode #(.PREFIX_CODE(PREFIX_CODE)) u_fields (
    .opc  (in_byte),
    .dec  (dec),
    .rsel (reg_sel),
    .msel (mode_sel)
  );

  assign opc_phase  = (phase == PH_OPC);
  assign dec_valid  = in_valid && opc_phase;
  assign start_word = dec.has_word;
  assign start_ext  = dec.prefix;
  assign ext_valid  = in_valid && (phase == PH_EXT);

  assign op_code  = 4'(dec.op);
  assign has_word = dec.has_word;
  assign inst_len = dec.len;
  assign illegal  = dec_valid && dec.illegal;
  assign prefix   = dec_valid && dec.prefix;

  idec_word_collect #(.W(WORD_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .start_word (start_word),
    .start_ext  (start_ext),
    .phase      (phase),
    .wvalid     (word_valid),
    .wvalue     (word_value)
  );

  p_prefix_not_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(prefix && illegal));
  p_illegal_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!has_word && inst_len == 2'd1));
  p_decode_only_opc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && ext_valid));
  p_after_illegal_opc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> opc_phase);
  p_jump_has_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && op_code == 4'd7) |-> (has_word && inst_len == 2'd3));
endmodule

// File: tb/opbyte_decoder_tb.sv
`timescale 1ns/1ps
module opbyte_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        dec_valid, has_word, illegal, prefix, ext_valid, word_valid;
  logic [3:0]  op_code;
  logic [1:0]  reg_sel, inst_len;
  logic [2:0]  mode_sel;
  logic [15:0] word_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          ph = 0;
  int          nb = 0;
  logic [15:0] acc = 16'h0;
  bit          exp_wv = 1'b0;
  logic [15:0] exp_wval = 16'h0;

  always #4 clk = ~clk;

  opbyte_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dec_valid(dec_valid), .op_code(op_code), .reg_sel(reg_sel),
    .mode_sel(mode_sel), .has_word(has_word), .inst_len(inst_len),
    .illegal(illegal), .prefix(prefix), .ext_valid(ext_valid),
    .word_valid(word_valid), .word_value(word_value)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: expected op for a byte, by value range.
  function automatic int ref_op(input logic [7:0] b);
    int v = int'(b);
    if (v == 255) return 15;
    if (v < 8)    return (v >= 3) ? 9 + (v - 3) : 14;
    if (v < 16)   return (v == 15) ? 14 : 7;
    if (v < 24)   return (v == 23) ? 14 : 8;
    if (v < 32)   return 14;
    if (v >= 224) return ((v % 8) >= 4 && (v % 8) <= 6) ? 6 : 14;
    return (v / 32) - 1;
  endfunction

  function automatic bit ref_word(input logic [7:0] b);
    int op = ref_op(b);
    if (op == 7) return 1'b1;
    if (op == 14 || op == 15 || op >= 9) return 1'b0;
    return (int'(b) % 8) >= 5;
  endfunction

  function automatic string ref_tag(input logic [7:0] b);
    int v = int'(b);
    if (v == 255)  return "R8";
    if (v < 8)     return "R5";
    if (v < 16)    return "R6";
    if (v < 24)    return "R7";
    if (v < 32)    return "R5";
    if (v >= 224)  return "R4";
    return "R2";
  endfunction

  task automatic step(input bit v, input logic [7:0] b);
    int    eop;
    bit    ew;
    string t;
    @(negedge clk);
    check(word_valid === exp_wv, "R9 word_valid", 32'(word_valid), 32'(exp_wv));
    if (exp_wv)
      check(word_value === exp_wval, "R9 word_value", 32'(word_value), 32'(exp_wval));
    in_valid = v;
    in_byte  = b;
    #1;
    if (v && ph == 0) begin
      eop = ref_op(b);
      ew  = ref_word(b);
      t   = ref_tag(b);
      check(dec_valid === 1'b1, "R10 dec_valid", 32'(dec_valid), 32'd1);
      check(op_code === 4'(eop), t, 32'(op_code), 32'(eop));
      check(reg_sel === b[4:3] && mode_sel === b[2:0], "R1 fields",
            {27'd0, reg_sel, mode_sel}, {27'd0, b[4:3], b[2:0]});
      check(has_word === ew, "R3 has_word", 32'(has_word), 32'(ew));
      check(inst_len === ((eop == 15) ? 2'd0 : (ew ? 2'd3 : 2'd1)), "R3 inst_len",
            32'(inst_len), (eop == 15) ? 32'd0 : (ew ? 32'd3 : 32'd1));
      check(illegal === (eop == 14), {t, " illegal"}, 32'(illegal), 32'(eop == 14));
      check(prefix === (eop == 15), "R8 prefix", 32'(prefix), 32'(eop == 15));
    end else begin
      check(dec_valid === 1'b0, "R10 no decode", 32'(dec_valid), 32'd0);
    end
    check(ext_valid === (v && ph == 2), "R8 ext_valid", 32'(ext_valid), 32'(v && ph == 2));
    exp_wv = 1'b0;
    if (v) begin
      case (ph)
        0: begin
          if (ref_op(b) == 15) ph = 2;
          else if (ref_word(b)) begin ph = 1; nb = 0; end
        end
        1: begin
          acc = {b, acc[15:8]};
          nb++;
          if (nb == 2) begin ph = 0; exp_wv = 1'b1; exp_wval = acc; end
        end
        default: ph = 0;
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(word_valid === 1'b0, "R11 word_valid reset", 32'(word_valid), 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b1; in_byte = 8'h3F;
    #1;
    check(dec_valid === 1'b1, "R11 opcode phase after reset", 32'(dec_valid), 32'd1);
    in_valid = 1'b0;
    // Directed: every opcode, operand bytes with an idle gap between them.
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 8'(i));
      if (ph == 1) begin
        step(1'b1, 8'(i ^ 8'h5A));
        step(1'b0, 8'hEE);
        step(1'b1, 8'(8'hC3 - i));
      end else if (ph == 2) begin
        step(1'b1, 8'hEB);
      end
      step(1'b0, 8'h00);
    end
    // Directed: prefix followed by a byte that looks like a jump (R8).
    step(1'b1, 8'hFF);
    step(1'b1, 8'h08);
    step(1'b1, 8'h0F);
    // Random stream.
    for (int k = 0; k < 6000; k++)
      step(($urandom % 4) != 0, 8'($urandom));
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule